// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of an eight-channel successive-approximation converter. It derives a conversion-step enable from the system clock and starts a sequence on a software write or on a falling edge of an external trigger pin. It chooses the analog channel for each conversion according to one of five scan modes, runs the binary search against a single comparator input, and records every finished conversion in a result register for that channel. The analog parts stay outside. The block drives the multiplexer select (`conv_chan`) and the trial code (`dac_code`), and it reads back a single comparator bit (`cmp_in`).

Each channel conversion has a fixed length in conversion steps. That length depends on the resolution (8 or 10 bits) and on whether the sample-and-hold profile is selected. A step opens with a short sampling interval. Bits are then decided from the most significant down, and idle steps fill the rest of the slot. One-shot and single-sweep runs stop by themselves and raise a one-cycle completion pulse. The continuous modes keep going until software writes the start flag to 0. Results are held in registers and are read through a plain combinational read port, so no stream handshake is involved. Configuration inputs are expected to stay stable while `busy` is high.

Top module: `sar_seq`

## Requirements
- R1: `cfg_div` = n (0..3) gives one conversion step every n+1 clocks, so one channel occupies its step count times (n+1) clocks.
- R2: A channel lasts 49 steps (8-bit) or 59 steps (10-bit) with `cfg_sh`=0, and 28 steps (8-bit) or 33 steps (10-bit) with `cfg_sh`=1.
- R3: Bits are decided MSB first. A trial bit is kept when `cmp_in`=1, meaning the input is at or above `dac_code`. With `cfg_res10`=1 the stored result equals the 10-bit input code.
- R4: With `cfg_res10`=0 the 8-bit trial code is placed on `dac_code[9:2]` with `dac_code[1:0]`=0. The stored result is right-aligned in bits 7:0, and bits 9:8 read as zero.
- R5: Mode 0 (and the unused codes 5 to 7) is one-shot. It converts `cfg_chan` once and then clears `busy` and pulses `done_irq` high for exactly one clock.
- R6: Mode 1 converts `cfg_chan` over and over until software stops it. Stopping gives no `done_irq`.
- R7: Mode 2 converts channels 0 to G-1 in ascending order once, where G = 2*(`cfg_grp`+1), and then finishes as in R5.
- R8: Mode 3 repeats the ascending 0 to G-1 order continuously.
- R9: Mode 4 repeats the order P,0,P,1,...,P,G-1, with priority channel P = `cfg_chan`.
- R10: A `start_wr` with `start_wdata`=1 while idle sets `busy` at that clock edge and starts from the first channel. The same write while busy is ignored. A write with `start_wdata`=0 stops the run.
- R11: With `trig_en`=1, a high-to-low transition of `trig_n` starts the sequence, or restarts it from the first channel and step 0 if it is already running. With `trig_en`=0 the transition is ignored.
- R12: After reset, `busy`=0, `done_irq`=0 and every result register reads 0. `rd_data` shows the result register selected by `rd_chan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 3 | Scan mode code (0 one-shot, 1 repeat, 2 sweep, 3 looping sweep, 4 priority sweep) |
| cfg_chan | input | 3 | Channel for modes 0/1, priority channel for mode 4 |
| cfg_grp | input | 2 | Sweep group size code, G = 2*(code+1) |
| cfg_res10 | input | 1 | 1 selects 10-bit resolution, 0 selects 8-bit |
| cfg_sh | input | 1 | 1 selects the sample-and-hold timing profile |
| cfg_div | input | 2 | Conversion step divider code |
| start_wr | input | 1 | Write strobe for the start flag |
| start_wdata | input | 1 | Value written to the start flag |
| trig_en | input | 1 | Enables the external trigger |
| trig_n | input | 1 | External trigger pin, active on falling edge |
| busy | output | 1 | Start flag readback, high while converting |
| done_irq | output | 1 | One-clock completion pulse |
| conv_chan | output | 3 | Analog multiplexer select |
| dac_code | output | 10 | Trial code for the capacitor DAC |
| cmp_in | input | 1 | Comparator result, 1 when input is at or above `dac_code` |
| rd_chan | input | 3 | Result register select |
| rd_data | output | 10 | Selected result register |

## Verification
A comparator model converts a per-channel input code into `cmp_in`. The input codes include all zeros, all ones, the mid-scale neighbours 511 and 512, alternating bit patterns and values one away from either end. These expose a wrong keep rule, a wrong bit order or an off-by-one step. Every scan mode runs under different divider, resolution and sample-and-hold settings, so a wrong step length or divider period shows up as a `busy` or channel-select mismatch in a specific clock. Extra stimulus covers a start written during a run, a mid-run external retrigger and a trigger edge with the trigger disabled. These separate a proper restart from an ignored one.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [2:0] {
    M_ONCE   = 3'd0,
    M_REPEAT = 3'd1,
    M_SWEEP  = 3'd2,
    M_LOOP   = 3'd3,
    M_PRIO   = 3'd4
  } scan_mode_e;

  localparam int STEPS_8    = 49;
  localparam int STEPS_10   = 59;
  localparam int STEPS_SH8  = 28;
  localparam int STEPS_SH10 = 33;

  function automatic int conv_len(input logic res10, input logic sh);
    if (sh) return res10 ? STEPS_SH10 : STEPS_SH8;
    return res10 ? STEPS_10 : STEPS_8;
  endfunction

endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
  parameter int DIVW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  assign tick = run && !restart && (cnt == div);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || !run)   cnt <= '0;
    else if (tick)              cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick); // R1

endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int RESW = 10,
  parameter int LOWW = 8,
  parameter int CNTW = 6,
  parameter int SAMP = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic            tick,
  input  logic            res10,
  input  logic            sh,
  input  logic            cmp_in,
  output logic [RESW-1:0] dac_code,
  output logic [RESW-1:0] result,
  output logic            chan_done
);
  localparam int BITW  = $clog2(RESW + 1);
  localparam int SHIFT = RESW - LOWW;

  logic [CNTW-1:0] cnt, last_step, off;
  logic [BITW-1:0] nbits, bitpos;
  logic            in_bits;
  logic [RESW-1:0] acc, trial;

  assign last_step = CNTW'(sar_pkg::conv_len(res10, sh) - 1);
  assign nbits     = res10 ? BITW'(RESW) : BITW'(LOWW);
  assign off       = cnt - CNTW'(SAMP);
  assign in_bits   = (cnt >= CNTW'(SAMP)) && (off < CNTW'(nbits));
  assign bitpos    = nbits - BITW'(1) - off[BITW-1:0];
  assign trial     = in_bits ? (acc | (RESW'(1) << bitpos)) : acc;
  assign dac_code  = res10 ? trial : (trial << SHIFT);
  assign chan_done = tick && (cnt == last_step);
  assign result    = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
    end else if (restart || !run) begin
      cnt <= '0;
      acc <= '0;
    end else if (tick) begin
      if (cnt == last_step) begin
        cnt <= '0;
        acc <= '0;
      end else begin
        cnt <= cnt + 1'b1;
        if (in_bits && cmp_in) acc <= trial;
      end
    end
  end

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_step); // R2
  AST_NARROW_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_done && !res10) |-> (result[RESW-1:LOWW] == '0)); // R4

endmodule

// File: rtl/sar_chsel.sv
module sar_chsel #(
  parameter int NCH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   restart,
  input  logic                   adv,
  input  logic [2:0]             mode,
  input  logic [$clog2(NCH)-1:0] sel,
  input  logic [$clog2(NCH)-2:0] grp,
  output logic [$clog2(NCH)-1:0] chan,
  output logic                   last
);
  import sar_pkg::*;
  localparam int CHW  = $clog2(NCH);
  localparam int POSW = CHW + 1;

  logic [POSW-1:0] pos, end_grp, end_prio, wrap;
  logic            is_once;

  assign end_grp  = POSW'({grp, 1'b1});
  assign end_prio = POSW'({grp, 2'b11});
  assign is_once  = !(mode inside {M_REPEAT, M_SWEEP, M_LOOP, M_PRIO});

  always_comb begin
    case (mode)
      M_SWEEP, M_LOOP: begin chan = pos[CHW-1:0];               wrap = end_grp;  end
      M_PRIO:          begin chan = pos[0] ? pos[CHW:1] : sel;  wrap = end_prio; end
      default:         begin chan = sel;                        wrap = '0;       end
    endcase
  end

  assign last = is_once || ((mode == M_SWEEP) && (pos == end_grp));

  always_ff @(posedge clk) begin
    if (!rst_n)        pos <= '0;
    else if (restart)  pos <= '0;
    else if (adv)      pos <= (pos == wrap) ? '0 : pos + 1'b1;
  end

  AST_PRIO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_PRIO) && !pos[0]) |-> (chan == sel)); // R9

endmodule

// File: rtl/sar_resbank.sv
module sar_resbank #(
  parameter int NCH  = 8,
  parameter int RESW = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [$clog2(NCH)-1:0] wchan,
  input  logic [RESW-1:0]        wdata,
  input  logic [$clog2(NCH)-1:0] rchan,
  output logic [RESW-1:0]        rdata
);
  localparam int CHW = $clog2(NCH);
  logic [RESW-1:0] regs [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                          regs[c] <= '0;
      else if (wr && wchan == CHW'(c))     regs[c] <= wdata;
    end
  end

  assign rdata = regs[rchan];

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NCH  = 8,
  parameter int RESW = 10,
  parameter int DIVW = 2,
  parameter int SAMP = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             cfg_mode,
  input  logic [$clog2(NCH)-1:0] cfg_chan,
  input  logic [$clog2(NCH)-2:0] cfg_grp,
  input  logic                   cfg_res10,
  input  logic                   cfg_sh,
  input  logic [DIVW-1:0]        cfg_div,
  input  logic                   start_wr,
  input  logic                   start_wdata,
  input  logic                   trig_en,
  input  logic                   trig_n,
  output logic                   busy,
  output logic                   done_irq,
  output logic [$clog2(NCH)-1:0] conv_chan,
  output logic [RESW-1:0]        dac_code,
  input  logic                   cmp_in,
  input  logic [$clog2(NCH)-1:0] rd_chan,
  output logic [RESW-1:0]        rd_data
);
  localparam int CNTW = $clog2(sar_pkg::STEPS_10 + 1);

  logic run, trig_q, sw_start, sw_stop, ext_start, restart;
  logic tick, chan_done, last, end_evt;
  logic [RESW-1:0] result;

  assign sw_start  = start_wr && start_wdata && !run;
  assign sw_stop   = start_wr && !start_wdata;
  assign ext_start = trig_en && trig_q && !trig_n;
  assign restart   = sw_start || ext_start;
  assign end_evt   = chan_done && last && !sw_stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      trig_q   <= 1'b1;
      done_irq <= 1'b0;
    end else begin
      trig_q   <= trig_n;
      done_irq <= end_evt;
      if (restart)                   run <= 1'b1;
      else if (sw_stop || end_evt)   run <= 1'b0;
    end
  end

  assign busy = run;

  sar_clkdiv #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .div(cfg_div), .tick(tick)
  );

  sar_core #(.RESW(RESW), .LOWW(8), .CNTW(CNTW), .SAMP(SAMP)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .tick(tick),
    .res10(cfg_res10), .sh(cfg_sh), .cmp_in(cmp_in),
    .dac_code(dac_code), .result(result), .chan_done(chan_done)
  );

  sar_chsel #(.NCH(NCH)) u_chsel (
    .clk(clk), .rst_n(rst_n), .restart(restart), .adv(chan_done),
    .mode(cfg_mode), .sel(cfg_chan), .grp(cfg_grp),
    .chan(conv_chan), .last(last)
  );

  sar_resbank #(.NCH(NCH), .RESW(RESW)) u_res (
    .clk(clk), .rst_n(rst_n), .wr(chan_done), .wchan(conv_chan),
    .wdata(result), .rchan(rd_chan), .rdata(rd_data)
  );

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !busy); // R5
  AST_TRIG_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !trig_en && !start_wr) |=> !busy); // R11

endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
  localparam int NCH = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [2:0] cfg_mode = '0, cfg_chan = '0;
  logic [1:0] cfg_grp = '0, cfg_div = '0;
  logic       cfg_res10 = 1'b1, cfg_sh = 1'b0;
  logic       start_wr = 1'b0, start_wdata = 1'b0, trig_en = 1'b0, trig_n = 1'b1;
  logic       busy, done_irq, cmp_in;
  logic [2:0] conv_chan, rd_chan = '0;
  logic [9:0] dac_code, rd_data;

  int vin [NCH];
  assign cmp_in = (vin[conv_chan] >= int'(dac_code));

  sar_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_chan(cfg_chan),
    .cfg_grp(cfg_grp), .cfg_res10(cfg_res10), .cfg_sh(cfg_sh), .cfg_div(cfg_div),
    .start_wr(start_wr), .start_wdata(start_wdata), .trig_en(trig_en), .trig_n(trig_n),
    .busy(busy), .done_irq(done_irq), .conv_chan(conv_chan), .dac_code(dac_code),
    .cmp_in(cmp_in), .rd_chan(rd_chan), .rd_data(rd_data)
  );

  int checks = 0, errors = 0;
  string tag = "R12";
  bit f_sw1 = 0, f_sw0 = 0, f_trig = 0;
  bit m_active = 0, m_done = 0;
  int m_k = 0;
  int exp_res [NCH];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int len_of();
    if (cfg_sh) return cfg_res10 ? 33 : 28;
    return cfg_res10 ? 59 : 49;
  endfunction
  function automatic int slot_of();
    return len_of() * (int'(cfg_div) + 1);
  endfunction
  function automatic int grp_sz();
    return 2 * (int'(cfg_grp) + 1);
  endfunction
  function automatic int chan_of(int j);
    int q;
    case (cfg_mode)
      3'd2: return j;
      3'd3: return j % grp_sz();
      3'd4: begin
        q = j % (2 * grp_sz());
        return (q % 2 == 0) ? int'(cfg_chan) : q / 2;
      end
      default: return int'(cfg_chan);
    endcase
  endfunction
  function automatic int seq_len();
    case (cfg_mode)
      3'd1, 3'd3, 3'd4: return 0;
      3'd2: return grp_sz();
      default: return 1;
    endcase
  endfunction

  // behavioural reference model, advanced on every clock edge
  always @(posedge clk) begin
    int j, ch;
    if (!rst_n) begin
      m_active = 0; m_done = 0; m_k = 0;
    end else begin
      m_done = 0;
      if ((f_sw1 && !m_active) || (f_trig && trig_en)) begin
        m_active = 1; m_k = 0;
      end else if (f_sw0) begin
        m_active = 0;
      end else if (m_active) begin
        m_k++;
        if (m_k % slot_of() == 0) begin
          j = m_k / slot_of();
          ch = chan_of(j - 1);
          exp_res[ch] = cfg_res10 ? vin[ch] : vin[ch] / 4;
          if (seq_len() != 0 && j == seq_len()) begin
            m_active = 0; m_done = 1;
          end
        end
      end
    end
  end

  // compare against the model on every clock
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(tag, "busy", busy, m_active);
      chk(tag, "done_irq", done_irq, m_done);
      if (m_active) begin
        chk(tag, "conv_chan", conv_chan, chan_of(m_k / slot_of()));
        if (!cfg_res10) chk("R4", "dac_code low bits", dac_code[1:0], 0);
      end
    end
  end

  task automatic sw_write(input bit v);
    @(negedge clk);
    start_wr = 1; start_wdata = v;
    if (v) f_sw1 = 1; else f_sw0 = 1;
    @(negedge clk);
    start_wr = 0; f_sw1 = 0; f_sw0 = 0;
  endtask

  task automatic trig_fall();
    @(negedge clk);
    trig_n = 0; f_trig = 1;
    @(negedge clk);
    f_trig = 0;
    repeat (2) @(negedge clk);
    trig_n = 1;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 20000) begin
      n++;
      @(negedge clk);
    end
    if (busy) chk(tag, "wait_idle timeout", 1, 0);
  endtask

  task automatic check_results(string req);
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk);
      rd_chan = 3'(c);
      #1 chk(req, "result register", rd_data, exp_res[c]);
    end
  endtask

  task automatic setup(string t, int mode, int ch, int grp, bit r10, bit sh, int dv);
    @(negedge clk);
    tag = t;
    cfg_mode = 3'(mode); cfg_chan = 3'(ch); cfg_grp = 2'(grp);
    cfg_res10 = r10; cfg_sh = sh; cfg_div = 2'(dv);
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    for (int c = 0; c < NCH; c++) begin vin[c] = 0; exp_res[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12", "reset busy", busy, 0);
    chk("R12", "reset done_irq", done_irq, 0);
    check_results("R12");

    // one-shot, 10-bit, no S/H, div 1
    vin = '{0, 1023, 512, 511, 341, 682, 1, 1022};
    setup("R5 R3 R2", 0, 5, 0, 1, 0, 0);
    sw_write(1);
    wait_idle(n);
    chk("R2", "one-shot 10-bit busy cycles", n, 59);
    check_results("R3");

    // one-shot, 8-bit, S/H, div 4
    setup("R1 R4 R5", 0, 2, 0, 0, 1, 3);
    sw_write(1);
    wait_idle(n);
    chk("R1", "div4 8-bit S/H busy cycles", n, 28 * 4);
    check_results("R4");

    // single sweep over all 8 channels
    vin = '{1023, 0, 511, 512, 682, 341, 1022, 1};
    setup("R7", 2, 0, 3, 1, 1, 1);
    sw_write(1);
    wait_idle(n);
    chk("R7", "sweep busy cycles", n, 8 * 33 * 2);
    check_results("R7");

    // repeat on one channel, stopped by software
    vin[3] = 777;
    setup("R6", 1, 3, 0, 0, 0, 2);
    sw_write(1);
    repeat (515) @(negedge clk);
    sw_write(0);
    chk("R6", "busy after stop", busy, 0);
    check_results("R6");

    // looping sweep over 4 channels
    vin = '{100, 200, 300, 400, 500, 600, 700, 800};
    setup("R8", 3, 0, 1, 1, 1, 0);
    sw_write(1);
    repeat (208) @(negedge clk);
    sw_write(0);
    check_results("R8");

    // priority-interleaved sweep
    vin = '{5, 1000, 6, 7, 8, 9, 640, 10};
    setup("R9", 4, 6, 0, 1, 0, 0);
    sw_write(1);
    repeat (418) @(negedge clk);
    sw_write(0);
    check_results("R9");

    // start written while busy is ignored
    vin[7] = 300;
    setup("R10", 0, 7, 0, 1, 1, 1);
    sw_write(1);
    repeat (20) @(negedge clk);
    sw_write(1);
    wait_idle(n);
    chk("R10", "remaining cycles after ignored start", n, 66 - 22);
    check_results("R10");

    // external trigger with retrigger
    vin[0] = 123; vin[1] = 456;
    setup("R11", 2, 0, 0, 1, 1, 0);
    trig_en = 1;
    trig_fall();
    repeat (40) @(negedge clk);
    vin[0] = 900;
    trig_fall();
    wait_idle(n);
    check_results("R11");

    // trigger edge ignored when disabled
    @(negedge clk);
    trig_en = 0;
    trig_fall();
    repeat (3) @(negedge clk);
    chk("R11", "busy after disabled trigger", busy, 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule